// File: doc/BRIEF.md
# Octal Flash Command Frame Translator

This block sits between a flash controller front end and an octal serial shifter. The front end hands it a command descriptor written as if for a single-line device. The descriptor holds an 8-bit opcode, an address length in bytes with an address value, a dummy-clock count, a data direction and a data length. The block accepts one descriptor at a time and plays it out as a frame, one byte beat per clock, on an 8-bit bus. A phase tag travels with each beat.

The operating mode is sampled when a descriptor is accepted. With octal mode on, the opcode is first rewritten through a fixed table that can also change the address length, the address value and the dummy count. The frame then starts with a two-byte command: the opcode followed by its bitwise complement. Every phase of the frame is marked as using all eight lines. With octal mode off, the descriptor is sequenced exactly as given, with a one-byte command, and it is marked for the single-line path.

Each frame runs in the order command, address, dummy, data, and any phase of zero length is left out. During dummy clocks the bus is not driven. Write data is taken through a valid/ready pair, and read bytes sampled from the bus are offered through a second valid/ready pair.

Top module: `oct_cmd_framer`

## Requirements
- R1: In octal mode the command phase lasts two beats: the first carries the opcode after remapping, and the second carries its bitwise complement (a remapped read gives 0xEC then 0x13).
- R2: In octal mode the read opcodes 0x03, 0x0B, 0x13 and 0x0C are replaced by 0xEC with a dummy count of 20. The requested address length and value are kept.
- R3: In octal mode 0x02 becomes 0x12, 0xD8 becomes 0xDC and 0x20 becomes 0x21. Each is sent with a 4-byte address carrying the requested value.
- R4: In octal mode 0x5A is sent with a 4-byte address and 20 dummy clocks. 0x71 is sent with 4 dummy clocks and its requested address.
- R5: In octal mode 0x9F and 0x05 are sent with a 4-byte address of value 0 and 4 dummy clocks. 0x01 is sent with a 4-byte address of value 0 and its requested dummy count. 0x15 is sent with a 4-byte address of value 1 and its requested dummy count.
- R6: In octal mode an opcode outside the table keeps its opcode, address and dummy settings. It still gets the two-byte command, and bus_octal is 1 for its frame.
- R7: In single-line mode nothing is rewritten: the command is one beat carrying the opcode, the address and dummy settings are used as requested, and bus_octal is 0.
- R8: Address beats go out most significant byte first, with bus_oe high. Dummy beats hold bus_oe low for exactly the dummy count.
- R9: bus_phase encodes idle=0, command=1, address=2, dummy=3, data=4. Within a frame the phase never moves backwards, and a phase of zero length is skipped.
- R10: A data beat is counted only when wr_valid is high (write, rd_dir=0) or rd_ready is high (read, rd_dir=1). Write beats drive wr_data with bus_oe high. Read beats present bus_in on rd_data with rd_valid high. The frame ends after data_len beats.
- R11: req_ready is 1 only while idle, including right after reset. The mode in force for a frame is the one sampled at acceptance, even if octal_en changes during the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| octal_en | input | 1 | Octal mode select, sampled at acceptance |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Block idle, descriptor taken when valid |
| req_opcode | input | 8 | Single-line opcode |
| req_addr_len | input | AL_W | Address length in bytes |
| req_addr | input | 8*ADDR_BYTES | Address value |
| req_dummy | input | DUMMY_W | Dummy clock count |
| req_rd | input | 1 | 1 = read data phase, 0 = write |
| req_data_len | input | LEN_W | Data length in bytes |
| bus_out | output | 8 | Byte driven this beat |
| bus_oe | output | 1 | Bus driven this beat |
| bus_in | input | 8 | Byte sampled from the bus |
| bus_phase | output | 3 | Current phase code |
| bus_octal | output | 1 | 1 = eight lines, 0 = single line |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed when valid |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Read byte consumed when valid |

## Verification
The bench builds the block with ADDR_BYTES=4, DUMMY_W=6 and LEN_W=8. With a 4-byte address, every table entry that forces a full-width address can be tested. A 6-bit dummy count holds the forced value of 20. An 8-bit length keeps data phases short, so the table can cover every remapped opcode, an unlisted one and the single-line pass-through. The width of the shared beat counter is set by LEN_W. Directed runs stall both data handshakes and flip the mode input in the middle of a frame.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  localparam logic [7:0] OP_RD_OCT   = 8'hEC;
  localparam int         DUMMY_LONG  = 20;
  localparam int         DUMMY_SHORT = 4;
  localparam int         ADDR_FULL   = 4;

endpackage

// File: rtl/ocf_remap.sv
module ocf_remap #(
  parameter int ADDR_BYTES = 4,
  parameter int DUMMY_W    = 6,
  localparam int AL_W      = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic               octal_i,
  input  logic [7:0]         op_i,
  input  logic [AL_W-1:0]    alen_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DUMMY_W-1:0] dum_i,
  output logic [7:0]         op_o,
  output logic [AL_W-1:0]    alen_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DUMMY_W-1:0] dum_o
);
  import ocf_pkg::*;

  localparam logic [AL_W-1:0]    AL4   = AL_W'(ADDR_FULL);
  localparam logic [DUMMY_W-1:0] DLONG = DUMMY_W'(DUMMY_LONG);
  localparam logic [DUMMY_W-1:0] DSHRT = DUMMY_W'(DUMMY_SHORT);

  always_comb begin
    op_o   = op_i;
    alen_o = alen_i;
    addr_o = addr_i;
    dum_o  = dum_i;
    if (octal_i) begin
      case (op_i)
        8'h03, 8'h0B, 8'h13, 8'h0C: begin      // R2
          op_o  = OP_RD_OCT;
          dum_o = DLONG;
        end
        8'h02: begin op_o = 8'h12; alen_o = AL4; end   // R3
        8'hD8: begin op_o = 8'hDC; alen_o = AL4; end
        8'h20: begin op_o = 8'h21; alen_o = AL4; end
        8'h5A: begin alen_o = AL4; dum_o = DLONG; end   // R4
        8'h71: dum_o = DSHRT;
        8'h9F, 8'h05: begin                    // R5
          alen_o = AL4; addr_o = '0; dum_o = DSHRT;
        end
        8'h01: begin alen_o = AL4; addr_o = '0; end
        8'h15: begin alen_o = AL4; addr_o = ADDR_W'(1); end
        default: ;                             // R6
      endcase
    end
  end

  always_comb begin
    if (!octal_i)
      AST_SPI_PASS: assert (op_o == op_i && alen_o == alen_i &&
                            addr_o == addr_i && dum_o == dum_i); // R7
  end

endmodule

// File: rtl/ocf_sequencer.sv
module ocf_sequencer #(
  parameter int ADDR_BYTES = 4,
  parameter int DUMMY_W    = 6,
  parameter int LEN_W      = 12,
  localparam int AL_W      = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int CNT_W     = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               octal_i,
  input  logic [7:0]         op_i,
  input  logic [AL_W-1:0]    alen_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DUMMY_W-1:0] dum_i,
  input  logic               rd_i,
  input  logic [LEN_W-1:0]   dlen_i,
  output logic               idle_o,
  output logic [2:0]         phase_o,
  output logic [7:0]         bus_out,
  output logic               bus_oe,
  input  logic [7:0]         bus_in,
  output logic               bus_octal,
  input  logic [7:0]         wr_data,
  input  logic               wr_valid,
  output logic               wr_ready,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  input  logic               rd_ready
);
  import ocf_pkg::*;

  phase_e             phase_q, nph;
  logic [CNT_W-1:0]   cnt_q, ncnt;
  logic [7:0]         op_q;
  logic               oct_q, rd_q;
  logic [AL_W-1:0]    alen_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DUMMY_W-1:0] dum_q;
  logic [LEN_W-1:0]   dlen_q;
  logic               beat, last;
  logic [7:0]         addr_byte;
  logic [2:0]         ph_code;

  assign ph_code = phase_q;

  always_comb begin
    case (phase_q)
      PH_CMD, PH_ADDR, PH_DUMMY: beat = 1'b1;
      PH_DATA:                   beat = rd_q ? rd_ready : wr_valid;
      default:                   beat = 1'b0;
    endcase
    last = beat && (cnt_q == CNT_W'(1));
  end

  // next non-empty phase after the current one
  always_comb begin
    nph  = PH_IDLE;
    ncnt = '0;
    if (phase_q == PH_CMD && alen_q != '0) begin
      nph  = PH_ADDR;
      ncnt = CNT_W'(alen_q);
    end else if ((phase_q == PH_CMD || phase_q == PH_ADDR) && dum_q != '0) begin
      nph  = PH_DUMMY;
      ncnt = CNT_W'(dum_q);
    end else if (phase_q != PH_DATA && dlen_q != '0) begin
      nph  = PH_DATA;
      ncnt = CNT_W'(dlen_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      oct_q   <= 1'b0;
      rd_q    <= 1'b0;
      alen_q  <= '0;
      addr_q  <= '0;
      dum_q   <= '0;
      dlen_q  <= '0;
    end else if (start_i) begin
      phase_q <= PH_CMD;
      cnt_q   <= octal_i ? CNT_W'(2) : CNT_W'(1);
      op_q    <= op_i;
      oct_q   <= octal_i;
      rd_q    <= rd_i;
      alen_q  <= alen_i;
      addr_q  <= addr_i;
      dum_q   <= dum_i;
      dlen_q  <= dlen_i;
    end else if (last) begin
      phase_q <= nph;
      cnt_q   <= ncnt;
    end else if (beat) begin
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  // most significant remaining byte first
  always_comb begin
    addr_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_q == CNT_W'(i + 1)) addr_byte = addr_q[8*i +: 8];
  end

  always_comb begin
    bus_out = '0;
    bus_oe  = 1'b0;
    case (phase_q)
      PH_CMD: begin
        bus_out = (oct_q && cnt_q == CNT_W'(1)) ? ~op_q : op_q;
        bus_oe  = 1'b1;
      end
      PH_ADDR: begin
        bus_out = addr_byte;
        bus_oe  = 1'b1;
      end
      PH_DATA: if (!rd_q) begin
        bus_out = wr_data;
        bus_oe  = wr_valid;
      end
      default: ;
    endcase
  end

  assign idle_o    = (phase_q == PH_IDLE);
  assign phase_o   = ph_code;
  assign bus_octal = oct_q;
  assign wr_ready  = (phase_q == PH_DATA) && !rd_q;
  assign rd_valid  = (phase_q == PH_DATA) && rd_q;
  assign rd_data   = bus_in;

  AST_CMD_INVERSE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CMD && oct_q && cnt_q == CNT_W'(1)) |-> bus_out == ~$past(bus_out)); // R1
  AST_PHASE_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (ph_code != 3'd0 && $past(ph_code) != 3'd0) |-> ph_code >= $past(ph_code)); // R9
  AST_WRITE_STALL: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DATA && !rd_q && !wr_valid) |=> (phase_q == PH_DATA && $stable(cnt_q))); // R10
  AST_READ_STALL: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DATA && rd_q && !rd_ready) |=> (phase_q == PH_DATA && $stable(cnt_q))); // R10
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (ph_code != 3'd0 && $past(ph_code) != 3'd0) |-> $stable(bus_octal)); // R11

endmodule

// File: rtl/oct_cmd_framer.sv
module oct_cmd_framer #(
  parameter int ADDR_BYTES = 4,
  parameter int DUMMY_W    = 6,
  parameter int LEN_W      = 12,
  localparam int AL_W      = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               octal_en,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [7:0]         req_opcode,
  input  logic [AL_W-1:0]    req_addr_len,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DUMMY_W-1:0] req_dummy,
  input  logic               req_rd,
  input  logic [LEN_W-1:0]   req_data_len,
  output logic [7:0]         bus_out,
  output logic               bus_oe,
  input  logic [7:0]         bus_in,
  output logic [2:0]         bus_phase,
  output logic               bus_octal,
  input  logic [7:0]         wr_data,
  input  logic               wr_valid,
  output logic               wr_ready,
  output logic [7:0]         rd_data,
  output logic               rd_valid,
  input  logic               rd_ready
);

  logic [7:0]         m_op;
  logic [AL_W-1:0]    m_alen;
  logic [ADDR_W-1:0]  m_addr;
  logic [DUMMY_W-1:0] m_dum;
  logic               idle;

  ocf_remap #(.ADDR_BYTES(ADDR_BYTES), .DUMMY_W(DUMMY_W)) u_remap (
    .octal_i (octal_en),
    .op_i    (req_opcode),
    .alen_i  (req_addr_len),
    .addr_i  (req_addr),
    .dum_i   (req_dummy),
    .op_o    (m_op),
    .alen_o  (m_alen),
    .addr_o  (m_addr),
    .dum_o   (m_dum)
  );

  ocf_sequencer #(.ADDR_BYTES(ADDR_BYTES), .DUMMY_W(DUMMY_W), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (req_valid && idle),
    .octal_i   (octal_en),
    .op_i      (m_op),
    .alen_i    (m_alen),
    .addr_i    (m_addr),
    .dum_i     (m_dum),
    .rd_i      (req_rd),
    .dlen_i    (req_data_len),
    .idle_o    (idle),
    .phase_o   (bus_phase),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .bus_in    (bus_in),
    .bus_octal (bus_octal),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready)
  );

  assign req_ready = idle;

endmodule

// File: tb/sim_oct_cmd_framer.sv
module sim_oct_cmd_framer;

  localparam int AB = 4;
  localparam int DW = 6;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic octal_en = 1'b0, req_valid = 1'b0, req_rd = 1'b0;
  logic req_ready;
  logic [7:0] req_opcode = '0;
  logic [2:0] req_addr_len = '0;
  logic [31:0] req_addr = '0;
  logic [DW-1:0] req_dummy = '0;
  logic [LW-1:0] req_data_len = '0;
  logic [7:0] bus_out, rd_data;
  logic [7:0] bus_in = 8'h3C;
  logic [7:0] wr_data = 8'hA5;
  logic bus_oe, bus_octal, wr_ready, rd_valid;
  logic [2:0] bus_phase;
  logic wr_valid = 1'b1, rd_ready = 1'b1;

  int total = 0, fails = 0;

  always #10 clk = ~clk;

  oct_cmd_framer #(.ADDR_BYTES(AB), .DUMMY_W(DW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .octal_en(octal_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_opcode(req_opcode), .req_addr_len(req_addr_len),
    .req_addr(req_addr), .req_dummy(req_dummy), .req_rd(req_rd),
    .req_data_len(req_data_len), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .bus_phase(bus_phase), .bus_octal(bus_octal),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        oct;
    logic [7:0]  op;
    logic [2:0]  al;
    logic [31:0] ad;
    logic [5:0]  dm;
    logic        rd;
    logic [7:0]  dl;
    logic [7:0]  xop;
    logic [2:0]  xal;
    logic [31:0] xad;
    logic [5:0]  xdm;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1, 8'h03, 3'd3, 32'h00123456, 6'd0, 1'b1, 8'd4, 8'hEC, 3'd3, 32'h00123456, 6'd20}, // R2
    '{4'd2, 1'b1, 8'h0C, 3'd4, 32'h01020304, 6'd8, 1'b1, 8'd2, 8'hEC, 3'd4, 32'h01020304, 6'd20}, // R2
    '{4'd2, 1'b1, 8'h0B, 3'd3, 32'h000ABCDE, 6'd8, 1'b1, 8'd1, 8'hEC, 3'd3, 32'h000ABCDE, 6'd20}, // R2
    '{4'd2, 1'b1, 8'h13, 3'd4, 32'h11223344, 6'd0, 1'b1, 8'd3, 8'hEC, 3'd4, 32'h11223344, 6'd20}, // R2
    '{4'd3, 1'b1, 8'h02, 3'd3, 32'h00654321, 6'd0, 1'b0, 8'd5, 8'h12, 3'd4, 32'h00654321, 6'd0},  // R3
    '{4'd3, 1'b1, 8'hD8, 3'd3, 32'h00010000, 6'd0, 1'b0, 8'd0, 8'hDC, 3'd4, 32'h00010000, 6'd0},  // R3
    '{4'd3, 1'b1, 8'h20, 3'd3, 32'h00002000, 6'd0, 1'b0, 8'd0, 8'h21, 3'd4, 32'h00002000, 6'd0},  // R3
    '{4'd4, 1'b1, 8'h5A, 3'd3, 32'h00000010, 6'd8, 1'b1, 8'd4, 8'h5A, 3'd4, 32'h00000010, 6'd20}, // R4
    '{4'd4, 1'b1, 8'h71, 3'd4, 32'h00000300, 6'd0, 1'b1, 8'd1, 8'h71, 3'd4, 32'h00000300, 6'd4},  // R4
    '{4'd5, 1'b1, 8'h9F, 3'd0, 32'h00000000, 6'd0, 1'b1, 8'd3, 8'h9F, 3'd4, 32'h00000000, 6'd4},  // R5
    '{4'd5, 1'b1, 8'h05, 3'd0, 32'h00000055, 6'd0, 1'b1, 8'd1, 8'h05, 3'd4, 32'h00000000, 6'd4},  // R5
    '{4'd5, 1'b1, 8'h01, 3'd0, 32'h000000FF, 6'd0, 1'b0, 8'd2, 8'h01, 3'd4, 32'h00000000, 6'd0},  // R5
    '{4'd5, 1'b1, 8'h15, 3'd0, 32'h00000000, 6'd0, 1'b1, 8'd1, 8'h15, 3'd4, 32'h00000001, 6'd0},  // R5
    '{4'd9, 1'b1, 8'h06, 3'd0, 32'h00000000, 6'd0, 1'b0, 8'd0, 8'h06, 3'd0, 32'h00000000, 6'd0},  // R9
    '{4'd6, 1'b1, 8'hAB, 3'd2, 32'h0000BEEF, 6'd3, 1'b1, 8'd2, 8'hAB, 3'd2, 32'h0000BEEF, 6'd3},  // R6
    '{4'd7, 1'b0, 8'h03, 3'd3, 32'h00123456, 6'd8, 1'b1, 8'd2, 8'h03, 3'd3, 32'h00123456, 6'd8},  // R7
    '{4'd7, 1'b0, 8'h9F, 3'd0, 32'h00000000, 6'd0, 1'b1, 8'd3, 8'h9F, 3'd0, 32'h00000000, 6'd0},  // R7
    '{4'd7, 1'b0, 8'h02, 3'd3, 32'h00ABCDEF, 6'd0, 1'b0, 8'd2, 8'h02, 3'd3, 32'h00ABCDEF, 6'd0}   // R7
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic oct, input logic [7:0] op, input logic [2:0] al,
                       input logic [31:0] ad, input logic [5:0] dm, input logic rd,
                       input logic [7:0] dl);
    @(negedge clk);
    octal_en = oct; req_opcode = op; req_addr_len = al; req_addr = ad;
    req_dummy = dm; req_rd = rd; req_data_len = dl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    int ncmd = 0, nad = 0, ndum = 0, ndat = 0, g = 0;
    logic [7:0] c0 = '0, c1 = '0;
    logic [31:0] aobs = '0;
    bit aoe_bad = 0, dum_bad = 0, dat_bad = 0, busy_bad = 0;
    logic oct_seen;
    string tg;
    issue(v.oct, v.op, v.al, v.ad, v.dm, v.rd, v.dl);
    oct_seen = bus_octal;
    while (bus_phase != 3'd0 && g < 300) begin
      if (req_ready) busy_bad = 1;
      case (bus_phase)
        3'd1: begin
          if (ncmd == 0) c0 = bus_out; else c1 = bus_out;
          ncmd++;
        end
        3'd2: begin
          aobs = (aobs << 8) | 32'(bus_out);
          nad++;
          if (!bus_oe) aoe_bad = 1;
        end
        3'd3: begin
          ndum++;
          if (bus_oe) dum_bad = 1;
        end
        3'd4: begin
          ndat++;
          if (v.rd && !(rd_valid && rd_data == 8'h3C && !bus_oe)) dat_bad = 1;
          if (!v.rd && !(wr_ready && bus_oe && bus_out == 8'hA5)) dat_bad = 1;
        end
        default: ;
      endcase
      g++;
      @(negedge clk);
    end
    tg = $sformatf("R%0d", v.tag);
    if (v.oct)
      chk(ncmd == 2 && c0 == v.xop && c1 == ~v.xop, "R1", $sformatf("cmd bytes vec %0d", i),
          {8'(ncmd), 8'h0, c0, c1}, {8'd2, 8'h0, v.xop, ~v.xop});
    else
      chk(ncmd == 1 && c0 == v.xop, "R7", $sformatf("cmd byte vec %0d", i),
          {8'(ncmd), 16'h0, c0}, {8'd1, 16'h0, v.xop});
    chk(nad == int'(v.xal) && aobs == v.xad && !aoe_bad, {tg, "/R8"},
        $sformatf("address vec %0d", i), aobs, v.xad);
    chk(nad == int'(v.xal), {tg, "/R9"}, $sformatf("address beats vec %0d", i),
        32'(nad), 32'(v.xal));
    chk(ndum == int'(v.xdm) && !dum_bad, {tg, "/R8"}, $sformatf("dummy beats vec %0d", i),
        32'(ndum), 32'(v.xdm));
    chk(ndat == int'(v.dl) && !dat_bad, "R10", $sformatf("data beats vec %0d", i),
        32'(ndat), 32'(v.dl));
    chk(oct_seen == v.oct, v.oct ? "R6" : "R7", $sformatf("line width vec %0d", i),
        32'(oct_seen), 32'(v.oct));
    chk(!busy_bad && req_ready, "R11", $sformatf("ready vec %0d", i),
        32'(busy_bad), 32'd0);
  endtask

  // data handshake stall plus mid-frame mode change
  task automatic stall_test(input logic rd);
    int g = 0, nd = 0;
    bit held = 1;
    issue(1'b1, rd ? 8'h03 : 8'h02, 3'd3, 32'h00000102, 6'd0, rd, 8'd3);
    while (bus_phase != 3'd4 && g < 100) begin g++; @(negedge clk); end
    if (rd) rd_ready = 1'b0; else wr_valid = 1'b0;
    octal_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      if (bus_phase != 3'd4 || bus_oe) held = 0;
      @(negedge clk);
    end
    chk(held, "R10", rd ? "read stall" : "write stall", 32'(bus_phase), 32'd4);
    chk(bus_octal == 1'b1 && req_ready == 1'b0, "R11", "mode held mid frame",
        {30'h0, bus_octal, req_ready}, 32'h2);
    rd_ready = 1'b1; wr_valid = 1'b1;
    g = 0;
    while (bus_phase == 3'd4 && g < 100) begin nd++; g++; @(negedge clk); end
    chk(nd == 3 && bus_phase == 3'd0, "R10", "beats after stall", 32'(nd), 32'd3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after reset", 32'(req_ready), 32'd1);
    chk(bus_phase == 3'd0 && !bus_oe, "R9", "idle after reset", 32'(bus_phase), 32'd0);
    chk(!wr_ready && !rd_valid, "R10", "no data handshake at reset",
        {30'h0, wr_ready, rd_valid}, 32'd0);
    for (int i = 0; i < NV; i++) run_vec(i);
    stall_test(1'b0);
    stall_test(1'b1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule